// File: doc/BRIEF.md
# 64-bit Programmable Interval Timer

The block is a bus-mapped interval timer whose 64-bit counter advances on prescaled ticks taken from one of two tick-enable strobes. Software stops the timer and clears it, programs the mode, the period and the interrupt enable, and then launches it. The counter climbs from zero to the programmed period. On the tick that finds the counter equal to the period, the block flags a period event. In continuous mode the counter then wraps to zero and keeps running. In one-shot mode it halts at the period value. The event flag drives a level interrupt when that interrupt is enabled. Reading the status register clears the flag.

The counter is wider than the register bus, which is DATA_W bits wide (32 by default). Software therefore reads it in two halves, low word first. The low-word read copies the upper half into a shadow register, and the later high-word read returns that copy, so the two halves always belong to the same instant. The period is written in two halves as well. The high word is only staged, and the low-word write commits both halves together. Mode and period writes made while the timer runs are held back until the next launch from the stopped state.

The controller has two states, ST_IDLE and ST_COUNT. LAUNCH moves from ST_IDLE to ST_COUNT on a start request. WRAP keeps it in ST_COUNT when a continuous period ends. EXPIRE returns it to ST_IDLE when a one-shot period ends. ABORT, caused by a software reset, returns it to ST_IDLE from either state. Read data is combinational in the cycle that `bus_rd` is high. Read side effects and all writes take place at the clock edge that closes that cycle.

Top module: `pit_timer`

## Requirements
- R1: After reset every readable register reads zero, the timer is stopped and `irq` is low.
- R2: Writing 1 to control bit 0 while the timer is stopped launches it. The launch clears the counter and the prescaler and loads the staged mode and period. Control bit 0 reads 1 while the timer runs, and a start request while it runs has no effect.
- R3: Writing 1 to control bit 8 stops the timer and clears the counter, the prescaler and the status flag. If bit 0 is set in the same write, bit 8 takes priority and the timer stays stopped.
- R4: Mode bit 3 picks `gclk_tick` (1) or `pclk_tick` (0) as the tick source. Mode bits 11:8 hold a prescaler value P, and the counter advances once every P+1 source strobes.
- R5: While the timer runs, each prescaled tick adds one to the counter, except on the tick that finds the counter equal to the period. That tick sets status bit 0, and in continuous mode (mode bit 0 = 1) it returns the counter to zero. A period value N therefore spans N+1 ticks.
- R6: In one-shot mode (mode bit 0 = 0), the period tick stops the timer. The counter holds the period value and control bit 0 reads 0.
- R7: A write to the period high word is staged only and does not change the period readback. A write to the period low word commits the staged high word and the new low word as one value.
- R8: Reading the status register returns the flag in bit 0 and clears it at the end of the read. A period event in the same cycle leaves the flag set.
- R9: `irq` is high exactly when the status flag is set and interrupt-enable bit 0 is 1.
- R10: Reading the counter low word copies the counter's high half into a shadow register. Reading the counter high word returns that shadow, however many cycles lie between the two reads.
- R11: Mode and period writes made while the timer runs do not affect the running count. They take effect at the next launch.
- R12: The byte addresses are: control 0x00, mode 0x04, period low 0x08, period high 0x0C, interrupt enable 0x10, status 0x1C, counter low 0x20, counter high 0x24. Other addresses read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while bus_rd is high |
| pclk_tick | input | 1 | Default tick-enable strobe |
| gclk_tick | input | 1 | Alternate tick-enable strobe |
| irq | output | 1 | Level period interrupt |

## Verification
The bench builds the timer with DATA_W set to 16. This gives a 32-bit counter whose upper half first changes after 65,536 ticks. That brings two cases within a short run: a carry into the high word between a low-word read and the high-word read that follows it, and a period whose high half is non-zero. The bench drives the alternate strobe once every three cycles while the default strobe stays high. Small periods and prescaler values then make continuous wraps, one-shot halts, prescaled ticking and the blocked updates while running happen within tens of cycles.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } pit_state_e;

    localparam logic [5:0] A_CTRL  = 6'h00;
    localparam logic [5:0] A_MODE  = 6'h04;
    localparam logic [5:0] A_PERLO = 6'h08;
    localparam logic [5:0] A_PERHI = 6'h0C;
    localparam logic [5:0] A_IEN   = 6'h10;
    localparam logic [5:0] A_STAT  = 6'h1C;
    localparam logic [5:0] A_CNTLO = 6'h20;
    localparam logic [5:0] A_CNTHI = 6'h24;

    localparam int B_START   = 0;
    localparam int B_SWRST   = 8;
    localparam int B_CONT    = 0;
    localparam int B_GSEL    = 3;
    localparam int B_PRES_LO = 8;

endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
    parameter int PRES_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              gsel,
    input  logic [PRES_W-1:0] pres,
    input  logic              ptick,
    input  logic              gtick,
    output logic              tick
);
    localparam logic [PRES_W-1:0] ONE = {{(PRES_W-1){1'b0}}, 1'b1};

    logic [PRES_W-1:0] div_q;
    logic              src;
    logic              last;

    assign src  = gsel ? gtick : ptick;
    assign last = (div_q == pres);
    assign tick = en && src && last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clr) begin
            div_q <= '0;
        end else if (en && src) begin
            div_q <= last ? '0 : div_q + ONE;
        end
    end

    AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (div_q <= pres)); // R4

endmodule

// File: rtl/pit_count_fsm.sv
module pit_count_fsm
    import pit_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             swrst,
    input  logic             start,
    input  logic             tick,
    input  logic             cont,
    input  logic [CNT_W-1:0] period,
    output logic             running,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    pit_state_e state_q, state_d;
    logic       hit;

    assign hit = (count == period);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_COUNT;
            ST_COUNT: if (tick && hit && !cont) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (swrst) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        running = (state_q == ST_COUNT);
        expire  = running && tick && hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (swrst) begin
            count <= '0;
        end else if (!running && start) begin
            count <= '0;
        end else if (running && tick) begin
            if (hit) count <= cont ? '0 : count;
            else     count <= count + ONE;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (count <= period)); // R5
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && cont && !swrst) |=> (count == '0)); // R5
    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !cont && !swrst) |=> !running); // R6

endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PRES_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [5:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pclk_tick,
    input  logic              gclk_tick,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;

    logic              mode_cont, mode_gsel;
    logic [PRES_W-1:0] mode_pres;
    logic [DATA_W-1:0] per_hi_stage;
    logic [CNT_W-1:0]  per_q;
    logic              ien_q, stat_q;
    logic [DATA_W-1:0] shadow_hi;
    logic              act_cont, act_gsel;
    logic [PRES_W-1:0] act_pres;
    logic [CNT_W-1:0]  act_per;

    logic              running, expire, tick;
    logic [CNT_W-1:0]  count;
    logic              wr_ctrl, swrst, start, launch;
    logic              rd_stat, rd_cntlo;

    assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    assign swrst    = wr_ctrl && bus_wdata[B_SWRST];
    assign start    = wr_ctrl && bus_wdata[B_START] && !bus_wdata[B_SWRST];
    assign launch   = start && !running;
    assign rd_stat  = bus_rd && (bus_addr == A_STAT);
    assign rd_cntlo = bus_rd && (bus_addr == A_CNTLO);

    pit_prescaler #(.PRES_W(PRES_W)) u_pres (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (swrst || launch),
        .en    (running),
        .gsel  (act_gsel),
        .pres  (act_pres),
        .ptick (pclk_tick),
        .gtick (gclk_tick),
        .tick  (tick)
    );

    pit_count_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .swrst   (swrst),
        .start   (start),
        .tick    (tick),
        .cont    (act_cont),
        .period  (act_per),
        .running (running),
        .count   (count),
        .expire  (expire)
    );

    // Software-visible configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_cont    <= 1'b0;
            mode_gsel    <= 1'b0;
            mode_pres    <= '0;
            per_hi_stage <= '0;
            per_q        <= '0;
            ien_q        <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_MODE: begin
                    mode_cont <= bus_wdata[B_CONT];
                    mode_gsel <= bus_wdata[B_GSEL];
                    mode_pres <= bus_wdata[B_PRES_LO +: PRES_W];
                end
                A_PERHI: per_hi_stage <= bus_wdata;
                A_PERLO: per_q        <= {per_hi_stage, bus_wdata};
                A_IEN:   ien_q        <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    // Working copy, loaded only on launch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_cont <= 1'b0;
            act_gsel <= 1'b0;
            act_pres <= '0;
            act_per  <= '0;
        end else if (launch) begin
            act_cont <= mode_cont;
            act_gsel <= mode_gsel;
            act_pres <= mode_pres;
            act_per  <= per_q;
        end
    end

    // Status flag and coherent-read shadow
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q    <= 1'b0;
            shadow_hi <= '0;
        end else begin
            if (swrst)        stat_q <= 1'b0;
            else if (expire)  stat_q <= 1'b1;
            else if (rd_stat) stat_q <= 1'b0;
            if (rd_cntlo) shadow_hi <= count[CNT_W-1:DATA_W];
        end
    end

    assign irq = stat_q && ien_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_CTRL:  bus_rdata[B_START] = running;
                A_MODE: begin
                    bus_rdata[B_CONT]              = mode_cont;
                    bus_rdata[B_GSEL]              = mode_gsel;
                    bus_rdata[B_PRES_LO +: PRES_W] = mode_pres;
                end
                A_PERLO: bus_rdata    = per_q[DATA_W-1:0];
                A_PERHI: bus_rdata    = per_q[CNT_W-1:DATA_W];
                A_IEN:   bus_rdata[0] = ien_q;
                A_STAT:  bus_rdata[0] = stat_q;
                A_CNTLO: bus_rdata    = count[DATA_W-1:0];
                A_CNTHI: bus_rdata    = shadow_hi;
                default: bus_rdata    = '0;
            endcase
        end
    end

    AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !expire && !swrst) |=> !irq); // R8
    AST_SWRST_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        swrst |=> (!running && !irq)); // R3
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> ($stable(act_per) && $stable(act_pres))); // R11

endmodule

// File: tb/pit_timer_bench.sv
`timescale 1ns/1ps
module pit_timer_bench;
    localparam int DW = 16;
    localparam int CW = 2 * DW;
    localparam longint unsigned LMASK = (64'd1 << DW) - 1;
    localparam longint unsigned CMASK = (64'd1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          pclk_tick = 1'b1, gclk_tick = 1'b0;
    logic          irq;

    int n_chk = 0, n_bad = 0, gcnt = 0;
    bit finished = 0;

    // reference model state
    bit m_run, m_cont, m_gsel, m_acont, m_agsel, m_ien, m_stat;
    int m_pres, m_apres, m_div;
    longint unsigned m_per, m_aper, m_cnt, m_hi_stage, m_shadow;

    always #4 clk = ~clk;

    pit_timer #(.DATA_W(DW), .PRES_W(4)) u_pit_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pclk_tick(pclk_tick), .gclk_tick(gclk_tick), .irq(irq)
    );

    always @(negedge clk) begin
        gcnt = (gcnt + 1) % 3;
        gclk_tick = (gcnt == 0);
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_cont = 0; m_gsel = 0; m_acont = 0; m_agsel = 0;
            m_ien = 0; m_stat = 0; m_pres = 0; m_apres = 0; m_div = 0;
            m_per = 0; m_aper = 0; m_cnt = 0; m_hi_stage = 0; m_shadow = 0;
        end else begin
            bit sel, tk, hit, sw, st;
            sel = m_agsel ? gclk_tick : pclk_tick;
            tk  = m_run && sel && (m_div == m_apres);
            hit = tk && (m_cnt == m_aper);
            sw  = bus_wr && bus_addr == 6'h00 && bus_wdata[8];
            st  = bus_wr && bus_addr == 6'h00 && bus_wdata[0] && !bus_wdata[8];
            if (bus_rd && bus_addr == 6'h20) m_shadow = m_cnt >> DW;
            if (sw) begin
                m_run = 0; m_cnt = 0; m_div = 0;
            end else if (st && !m_run) begin
                m_run = 1; m_cnt = 0; m_div = 0;
                m_acont = m_cont; m_agsel = m_gsel; m_apres = m_pres; m_aper = m_per;
            end else if (m_run) begin
                if (sel) m_div = (m_div == m_apres) ? 0 : m_div + 1;
                if (tk) begin
                    if (hit) begin
                        if (m_acont) m_cnt = 0; else m_run = 0;
                    end else m_cnt = (m_cnt + 1) & CMASK;
                end
            end
            if (sw) m_stat = 0;
            else if (hit) m_stat = 1;
            else if (bus_rd && bus_addr == 6'h1C) m_stat = 0;
            if (bus_wr) begin
                case (bus_addr)
                    6'h04: begin m_cont = bus_wdata[0]; m_gsel = bus_wdata[3]; m_pres = int'(bus_wdata[11:8]); end
                    6'h0C: m_hi_stage = longint'(bus_wdata);
                    6'h08: m_per = (m_hi_stage << DW) | longint'(bus_wdata);
                    6'h10: m_ien = bus_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    function automatic longint unsigned model_rd(input logic [5:0] a);
        case (a)
            6'h00: return longint'(m_run);
            6'h04: return (longint'(m_pres) << 8) | (longint'(m_gsel) << 3) | longint'(m_cont);
            6'h08: return m_per & LMASK;
            6'h0C: return m_per >> DW;
            6'h10: return longint'(m_ien);
            6'h1C: return longint'(m_stat);
            6'h20: return m_cnt & LMASK;
            6'h24: return m_shadow;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // irq compared with the model on every clock (R9)
    always @(negedge clk) begin
        if (rst_n && !finished)
            chk(irq === (m_stat && m_ien), "R9 irq level", longint'(irq), longint'(m_stat && m_ien));
    end

    task automatic wr(input logic [5:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input string tag, output longint unsigned got);
        longint unsigned exp;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        exp = model_rd(a);
        got = longint'(bus_rdata);
        chk(got == exp, tag, got, exp);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        longint unsigned v, snap;
        logic [5:0] amap [9] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h1C, 6'h20, 6'h24, 6'h14};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R12 reset state and map
        foreach (amap[i]) begin
            rd(amap[i], "R1 reset read", v);
            chk(v == 0, "R1 reset literal", v, 0);
        end
        chk(irq == 1'b0, "R1 irq after reset", longint'(irq), 0);

        // R5 continuous, R8 status clear, R2 running bit
        wr(6'h00, 16'h0100); wr(6'h04, 16'h0001); wr(6'h0C, 16'h0000);
        wr(6'h08, 16'h0005); wr(6'h10, 16'h0001); wr(6'h00, 16'h0001);
        rd(6'h00, "R2 running bit", v);
        chk(v == 1, "R2 running literal", v, 1);
        idle(20);
        rd(6'h20, "R5 count low", v);
        rd(6'h1C, "R8 status read", v);
        chk(v == 1, "R8 status set literal", v, 1);
        rd(6'h1C, "R8 status after clear", v);
        wr(6'h14, 16'hFFFF);
        rd(6'h14, "R12 unmapped", v);
        chk(v == 0, "R12 unmapped literal", v, 0);

        // R4 alternate source with prescaler 2
        wr(6'h00, 16'h0100); wr(6'h04, 16'h0209); wr(6'h08, 16'h0003); wr(6'h00, 16'h0001);
        rd(6'h04, "R4 mode readback", v);
        chk(v == 16'h0209, "R4 mode literal", v, 16'h0209);
        repeat (12) begin idle(5); rd(6'h20, "R4 prescaled count", v); end

        // R6 one-shot with prescaler 1
        wr(6'h00, 16'h0100); wr(6'h04, 16'h0100); wr(6'h08, 16'h0004); wr(6'h00, 16'h0001);
        idle(30);
        rd(6'h00, "R6 halted", v);
        chk(v == 0, "R6 halted literal", v, 0);
        rd(6'h20, "R6 count holds", v);
        chk(v == 4, "R6 count literal", v, 4);
        rd(6'h1C, "R6 status", v);

        // R11 writes while running deferred
        wr(6'h00, 16'h0100); wr(6'h04, 16'h0001); wr(6'h08, 16'h000A); wr(6'h00, 16'h0001);
        wr(6'h08, 16'h0002); wr(6'h04, 16'h0301); wr(6'h00, 16'h0001);
        repeat (8) begin idle(3); rd(6'h20, "R11 old config count", v); end
        wr(6'h00, 16'h0100); wr(6'h00, 16'h0001);
        repeat (8) begin idle(3); rd(6'h20, "R11 new config count", v); end

        // R7 staged high word
        wr(6'h0C, 16'h0007);
        rd(6'h0C, "R7 high staged", v);
        chk(v == 0, "R7 high unchanged literal", v, 0);
        wr(6'h08, 16'h0009);
        rd(6'h0C, "R7 high committed", v);
        chk(v == 7, "R7 high literal", v, 7);
        rd(6'h08, "R7 low committed", v);

        // R3 reset with start in same write
        wr(6'h04, 16'h0001); wr(6'h0C, 16'h0000); wr(6'h08, 16'h0003);
        wr(6'h00, 16'h0100); wr(6'h00, 16'h0001); idle(10);
        wr(6'h00, 16'h0101);
        chk(irq == 1'b0, "R3 irq cleared", longint'(irq), 0);
        rd(6'h00, "R3 stopped", v);
        chk(v == 0, "R3 stopped literal", v, 0);
        rd(6'h1C, "R3 status cleared", v);
        chk(v == 0, "R3 status literal", v, 0);
        rd(6'h20, "R3 count cleared", v);
        chk(v == 0, "R3 count literal", v, 0);

        // R10 coherent read across a high-word carry; R9 gating with enable off
        wr(6'h10, 16'h0000);
        wr(6'h0C, 16'h0001); wr(6'h08, 16'h0020); wr(6'h00, 16'h0001);
        idle(65528);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 6'h20; #1;
        snap = m_cnt >> DW;
        chk(longint'(bus_rdata) == (m_cnt & LMASK), "R10 low read", longint'(bus_rdata), m_cnt & LMASK);
        @(negedge clk); bus_rd = 1'b0;
        idle(30);
        chk((m_cnt >> DW) != snap, "R10 carry occurred", m_cnt >> DW, snap);
        rd(6'h24, "R10 high shadow", v);
        chk(v == snap, "R10 coherent literal", v, snap);
        idle(40);
        rd(6'h1C, "R9 status while disabled", v);
        chk(v == 1, "R9 status set literal", v, 1);
        chk(irq == 1'b0, "R9 irq gated", longint'(irq), 0);
        rd(6'h20, "R10 second low", v);
        rd(6'h24, "R10 second high", v);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule